// File: doc/BRIEF.md
# 100 Mb/s Transmit Code-Group Encoder

This block sits between a MAC's 4-bit transmit path and the line side of a 100 Mb/s physical layer. It runs on a single bit clock and derives a symbol boundary every fifth cycle. On each boundary it takes one nibble together with its enable and error qualifiers. It then produces one 5-bit code-group, which it holds for the next five cycles. The same code-group also leaves serially, one bit per clock, so that a parallel or a serial consumer can use the block without any further logic.

Framing is handled in time and does not rely on a lookup alone. A quiet line carries the idle code-group. The rising edge of the enable turns the first two nibbles of a frame into a start delimiter pair. Nibbles flagged as errored become the error code-group. The fall of the enable produces an end delimiter pair, after which idle returns. The nibble source is paced by the `sym_tick` output: inputs must be stable during the cycle in which `sym_tick` is high.

Top module: `tx4b5b_encoder`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block returns to the idle state. In the first cycle after reset, `code_grp` is 11111 and `sym_tick` is 0. This also applies when reset arrives in the middle of a frame.
- R2: When no frame is in progress and `tx_en` is 0, the code-group sent is idle, 11111.
- R3: On the first symbol boundary with `tx_en` = 1, the block sends J (11000). On the following boundary it sends K (10001). Both ignore `txd` and `tx_er`.
- R4: After K, each nibble received with `tx_en` = 1 and `tx_er` = 0 is sent as data. The codes for values 0 to F are: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: During the data phase, a nibble received with `tx_en` = 1 and `tx_er` = 1 is sent as H (00100) instead of its data code.
- R6: The first boundary in the data phase with `tx_en` = 0 sends T (01101). The next boundary sends R (00111), whatever the inputs are. After R, the block is idle again: it sends I, or J if `tx_en` is 1.
- R7: `sym_tick` is high for exactly one cycle in every five. Inputs are sampled on the clock edge where `sym_tick` is high. `code_grp` changes only right after that edge and then holds for five cycles.
- R8: `ser_bit` sends the current code-group most significant bit first. In the k-th cycle after a symbol boundary (k = 0..4), it carries bit 4−k of `code_grp`.
- R9: A boundary in the data phase with `tx_en` = 0 sends T even if `tx_er` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, five cycles per code-group |
| rst_n | input | 1 | Synchronous active-low reset |
| txd | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame in progress |
| tx_er | input | 1 | Current nibble is errored |
| sym_tick | output | 1 | High in the cycle whose closing edge samples the inputs |
| code_grp | output | 5 | Current code-group |
| ser_bit | output | 1 | Serial code-group bit, MSB first |

## Verification
Two functions can meet on one boundary. The first is error substitution against the end delimiter: `tx_er` high in the same nibble where `tx_en` falls. The second is the start delimiter against the close of the previous frame: `tx_en` rising again on the boundary right after R. The vector table provokes both cases directly. Random frames of length zero and upward, with errors sprinkled in, are judged against an independent symbol-level model of the framer. Every code-group is also compared bit by bit with its serial form.

// File: rtl/tx4b5b_pkg.sv
// Shared constants and code-group lookup for the 4B/5B transmit encoder.
// Assumes the fixed 5-bit code-group alphabet of 100 Mb/s block coding.
package tx4b5b_pkg;
    localparam int NIB_W = 4;
    localparam int CG_W  = 5;
    localparam int PH_W  = $clog2(CG_W);

    localparam logic [CG_W-1:0] CG_I = 5'b11111;
    localparam logic [CG_W-1:0] CG_J = 5'b11000;
    localparam logic [CG_W-1:0] CG_K = 5'b10001;
    localparam logic [CG_W-1:0] CG_T = 5'b01101;
    localparam logic [CG_W-1:0] CG_R = 5'b00111;
    localparam logic [CG_W-1:0] CG_H = 5'b00100;

    typedef enum logic [1:0] {
        FS_QUIET = 2'd0,
        FS_SOF2  = 2'd1,
        FS_BODY  = 2'd2,
        FS_EOF2  = 2'd3
    } frm_state_t;

    // Data nibble to code-group mapping.
    function automatic logic [CG_W-1:0] nib_code(input logic [NIB_W-1:0] n);
        logic [CG_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/tx4b5b_symclk.sv
// Symbol phase counter: counts bit-clock cycles within one code-group
// and flags the last one. Assumes one code-group spans CG_W cycles.
module tx4b5b_symclk
    import tx4b5b_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            tick
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CG_W - 1);

    // Advance the phase, wrapping at the end of a code-group.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    // Boundary flag for the last bit of each code-group.
    always_comb tick = (phase == PH_LAST);

    // R7: the boundary flag is never high on two consecutive cycles.
    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R7: the phase never leaves its legal range.
    assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST);
endmodule

// File: rtl/tx4b5b_framer.sv
// Frame sequencer: turns the qualified nibble stream into code-groups,
// inserting idle, J/K, T/R and H. Assumes inputs are stable when tick is high.
module tx4b5b_framer
    import tx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NIB_W-1:0] txd,
    input  logic             tx_en,
    input  logic             tx_er,
    output logic [CG_W-1:0]  code
);
    frm_state_t      st, st_nx;
    logic [CG_W-1:0] code_nx;

    // Choose the next state and code-group from the current state and inputs.
    always_comb begin
        st_nx   = st;
        code_nx = CG_I;
        case (st)
            FS_QUIET: begin
                if (tx_en) begin
                    code_nx = CG_J;
                    st_nx   = FS_SOF2;
                end
            end
            FS_SOF2: begin
                code_nx = CG_K;
                st_nx   = FS_BODY;
            end
            FS_BODY: begin
                if (!tx_en) begin
                    code_nx = CG_T;
                    st_nx   = FS_EOF2;
                end else if (tx_er) begin
                    code_nx = CG_H;
                end else begin
                    code_nx = nib_code(txd);
                end
            end
            default: begin
                code_nx = CG_R;
                st_nx   = FS_QUIET;
            end
        endcase
    end

    // Commit state and code-group on each symbol boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= FS_QUIET;
            code <= CG_I;
        end else if (tick) begin
            st   <= st_nx;
            code <= code_nx;
        end
    end

    // R7: the code-group only changes right after a boundary.
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(code));
    // R3: K always follows J.
    assert_k_after_j_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code == CG_J) |=> code == CG_K);
    // R6: R always follows T.
    assert_r_after_t_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code == CG_T) |=> code == CG_R);
    // R6: after R only idle or a new start delimiter may follow.
    assert_quiet_after_r_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code == CG_R) |=> (code == CG_I || code == CG_J));
    // R2: idle is followed by idle or J only.
    assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code == CG_I) |=> (code == CG_I || code == CG_J));
endmodule

// File: rtl/tx4b5b_serial.sv
// Serial tap: selects one code-group bit per bit-clock cycle, MSB first.
// Assumes the code-group is held for the whole symbol period.
module tx4b5b_serial
    import tx4b5b_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [PH_W-1:0] phase,
    input  logic [CG_W-1:0] code,
    output logic            bit_o
);
    logic [PH_W-1:0] idx;

    // Map the phase to a bit position, highest first.
    always_comb begin
        idx   = PH_W'(CG_W - 1) - phase;
        bit_o = code[idx];
    end

    // R8: the first bit after a boundary is the new code-group's MSB.
    assert_msb_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> bit_o == code[CG_W-1]);
    // R8: the last bit before a boundary is the code-group's LSB.
    assert_lsb_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> bit_o == code[0]);
endmodule

// File: rtl/tx4b5b_encoder.sv
// Top level of the 100 Mb/s transmit code-group encoder: phase counter,
// frame sequencer and serial tap. Assumes one clock, five cycles per symbol.
module tx4b5b_encoder
    import tx4b5b_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] txd,
    input  logic             tx_en,
    input  logic             tx_er,
    output logic             sym_tick,
    output logic [CG_W-1:0]  code_grp,
    output logic             ser_bit
);
    logic [PH_W-1:0] phase;

    tx4b5b_symclk u_symclk (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .tick  (sym_tick)
    );

    tx4b5b_framer u_framer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sym_tick),
        .txd   (txd),
        .tx_en (tx_en),
        .tx_er (tx_er),
        .code  (code_grp)
    );

    tx4b5b_serial u_serial (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sym_tick),
        .phase (phase),
        .code  (code_grp),
        .bit_o (ser_bit)
    );
endmodule

// File: tb/tb_tx4b5b_encoder.sv
module tb_tx4b5b_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic       sym_tick;
    logic [4:0] code_grp;
    logic       ser_bit;

    int checks = 0;
    int errors = 0;
    int mst = 0;   // model state: 0 quiet, 1 after J, 2 body, 3 after T

    always #5 clk = ~clk;

    tx4b5b_encoder dut (
        .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
        .sym_tick(sym_tick), .code_grp(code_grp), .ser_bit(ser_bit)
    );

    // Vector: {tx_en, tx_er, txd[3:0], expected code[4:0]}
    localparam logic [10:0] VEC [32] = '{
        {2'b00, 4'h0, 5'b11111}, {2'b10, 4'h5, 5'b11000}, {2'b10, 4'h5, 5'b10001},
        {2'b10, 4'h0, 5'b11110}, {2'b10, 4'h1, 5'b01001}, {2'b10, 4'h2, 5'b10100},
        {2'b10, 4'h3, 5'b10101}, {2'b10, 4'h4, 5'b01010}, {2'b10, 4'h5, 5'b01011},
        {2'b10, 4'h6, 5'b01110}, {2'b10, 4'h7, 5'b01111}, {2'b10, 4'h8, 5'b10010},
        {2'b10, 4'h9, 5'b10011}, {2'b10, 4'hA, 5'b10110}, {2'b10, 4'hB, 5'b10111},
        {2'b10, 4'hC, 5'b11010}, {2'b10, 4'hD, 5'b11011}, {2'b10, 4'hE, 5'b11100},
        {2'b10, 4'hF, 5'b11101}, {2'b11, 4'h3, 5'b00100}, {2'b00, 4'h0, 5'b01101},
        {2'b00, 4'h0, 5'b00111}, {2'b00, 4'h0, 5'b11111}, {2'b11, 4'h7, 5'b11000},
        {2'b11, 4'h7, 5'b10001}, {2'b00, 4'h0, 5'b01101}, {2'b10, 4'h9, 5'b00111},
        {2'b10, 4'hA, 5'b11000}, {2'b10, 4'hA, 5'b10001}, {2'b01, 4'h2, 5'b01101},
        {2'b00, 4'h0, 5'b00111}, {2'b00, 4'h0, 5'b11111}
    };

    task automatic chk(input bit ok, input string req, input logic [4:0] act,
                       input logic [4:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Data code table written from R4, independent of the design.
    function automatic logic [4:0] ref_data(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    // Symbol-level model of framing (R2, R3, R5, R6, R9).
    function automatic logic [4:0] model(input logic en, input logic er,
                                         input logic [3:0] d);
        logic [4:0] c;
        case (mst)
            0: begin c = en ? 5'b11000 : 5'b11111; mst = en ? 1 : 0; end
            1: begin c = 5'b10001; mst = 2; end
            2: begin
                if (!en) begin c = 5'b01101; mst = 3; end
                else c = er ? 5'b00100 : ref_data(d);
            end
            default: begin c = 5'b00111; mst = 0; end
        endcase
        return c;
    endfunction

    // Drive one symbol, then check the parallel code (R7) and serial bits (R8).
    task automatic step(input logic en, input logic er, input logic [3:0] d,
                        input logic [4:0] exp, input string req);
        logic [4:0] sb;
        while (sym_tick !== 1'b1) @(negedge clk);
        tx_en = en; tx_er = er; txd = d;
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            sb[4-k] = ser_bit;
            if (k < 4 && sym_tick !== 1'b0)
                chk(1'b0, "R7 tick early", {4'b0, sym_tick}, 5'b0);
        end
        chk(code_grp === exp, req, code_grp, exp);
        chk(sym_tick === 1'b1, "R7 tick period", {4'b0, sym_tick}, 5'b1);
        chk(sb === exp, "R8 serial MSB first", sb, exp);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_grp === 5'b11111, "R1 reset idle", code_grp, 5'b11111);
        chk(sym_tick === 1'b1 || sym_tick === 1'b0, "R1 tick known", {4'b0, sym_tick}, 5'b0);

        // Table walk: data map, H, T/R, back-to-back frames, er with en low.
        for (int i = 0; i < 32; i++)
            step(VEC[i][10], VEC[i][9], VEC[i][8:5], VEC[i][4:0],
                 "R2 R3 R4 R5 R6 R9 vector");

        // Mid-frame reset returns to idle (R1).
        step(1'b1, 1'b0, 4'h5, 5'b11000, "R3 J before reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; tx_en = 1'b0;
        @(negedge clk);
        chk(code_grp === 5'b11111, "R1 reset mid-frame", code_grp, 5'b11111);
        chk(sym_tick === 1'b0, "R1 tick after reset", {4'b0, sym_tick}, 5'b0);
        mst = 0;

        // Random frames against the model, lengths 0..20, sparse errors.
        for (int f = 0; f < 30; f++) begin
            int len;
            len = $urandom_range(0, 20);
            for (int n = 0; n < len + 2; n++) begin
                logic er; logic [3:0] d; logic [4:0] e;
                er = ($urandom_range(0, 7) == 0);
                d  = 4'($urandom_range(0, 15));
                e  = model(1'b1, er, d);
                step(1'b1, er, d, e, "R4 R5 random frame");
            end
            for (int n = 0; n < 3; n++) begin
                logic er; logic [4:0] e;
                er = ($urandom_range(0, 1) == 0);
                e  = model(1'b0, er, 4'h0);
                step(1'b0, er, 4'h0, e, "R6 R9 random tail");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule